// File: doc/BRIEF.md
# Dual-Bus Manchester II Word Transmitter

This block turns one 16-bit word into a serial Manchester II frame of the kind used on dual-redundant avionics data buses. Each word is sent behind a three-bit-time sync pattern and followed by an odd parity bit that the block computes itself. The sync pattern is either command/status or data, and it is chosen separately for every word.

A load request carries the word, the sync type and a bus select. The block accepts the request only when it is idle. It latches all three values on that edge and drives the frame onto the complementary output pair of the chosen bus. The other bus stays quiet. Timing comes from the 12 MHz core clock: each half bit cell lasts 6 clocks, so a bit lasts 1 us and a whole frame lasts 240 clocks. A busy output covers the full frame. A new word can be loaded on the first cycle in which busy is low again.

Top module: `mtx_word_tx`

## Requirements
- R1: While reset is held, and directly after it is released, busy_o is 0 and all four bus outputs are 0.
- R2: A half bit cell lasts 6 clocks and a bit cell lasts 12. busy_o is 1 for exactly 240 cycles, starting the cycle after the load is accepted.
- R3: Bit-times 1 to 3 carry the sync. When cmd_sync_i=1, the positive line is high for 18 clocks and then low for 18. When cmd_sync_i=0, the positive line is low for 18 clocks and then high for 18.
- R4: Bit-times 4 to 19 carry data_i, most significant bit first. data_i[15] is in bit-time 4 and data_i[0] is in bit-time 19.
- R5: A 1 bit drives the positive line high for the first half of its cell and low for the second half. A 0 bit drives it low and then high.
- R6: Bit-time 20 carries a parity bit, encoded the same way as a data bit. The parity bit makes the number of ones in the 16 data bits plus parity odd.
- R7: While a frame is being sent, the negative line of the selected bus is always the complement of its positive line.
- R8: bus_sel_i=0 selects bus A and bus_sel_i=1 selects bus B. The value is captured at load. Changing bus_sel_i during a frame has no effect. Both lines of the bus that is not selected stay at 0.
- R9: When no frame is being sent, all four bus outputs are 0.
- R10: A load request while busy_o=1 is ignored and the frame in progress is unchanged. A load presented in the first cycle that busy_o is 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load request, accepted when busy_o is 0 |
| data_i | input | 16 | Word to send |
| cmd_sync_i | input | 1 | 1: command/status sync, 0: data sync |
| bus_sel_i | input | 1 | 0: bus A, 1: bus B |
| busy_o | output | 1 | High while a frame is being sent |
| bus_a_p_o | output | 1 | Bus A positive line |
| bus_a_n_o | output | 1 | Bus A negative line |
| bus_b_p_o | output | 1 | Bus B positive line |
| bus_b_n_o | output | 1 | Bus B negative line |

## Verification
The assertions assume that load_i, data_i, cmd_sync_i and bus_sel_i are known (not X) at every rising edge after reset. They also assume reset is only deasserted between edges. The bench changes every input only on the falling clock edge and always drives defined values. Random words and random sync and bus choices are mixed with directed words of all zeros, all ones and single set bits. During a frame the bench also changes bus_sel_i and raises load_i, to show that the captured values hold.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned SYNC_BITS    = 3;
  localparam int unsigned PARITY_BITS  = 1;
  localparam int unsigned FRAME_BITS   = SYNC_BITS + DATA_W + PARITY_BITS;
  localparam int unsigned FRAME_HALVES = 2 * FRAME_BITS;

  typedef enum logic {
    SYNC_DATA = 1'b0,
    SYNC_CMD  = 1'b1
  } sync_kind_e;

  typedef enum logic {
    BUS_A = 1'b0,
    BUS_B = 1'b1
  } bus_id_e;

  function automatic logic odd_parity(input logic [DATA_W-1:0] w);
    return ~(^w);
  endfunction
endpackage

// File: rtl/mtx_half_timer.sv
module mtx_half_timer #(
  parameter int unsigned HALF_CLKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic half_end_o
);
  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (start_i)             cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == LAST)          cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign half_end_o = run_i && (cnt_q == LAST);

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);  // R2
  AST_DIV_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == '0);  // R2
endmodule

// File: rtl/mtx_pattern_shifter.sv
module mtx_pattern_shifter
  import mtx_pkg::*;
#(
  parameter int unsigned DW        = DATA_W,
  parameter int unsigned SYNC_HALF = 2 * SYNC_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  sync_kind_e    sync_i,
  input  logic          shift_i,
  output logic          level_o
);
  localparam int unsigned NH     = SYNC_HALF + 2 * DW + 2;
  localparam int unsigned SYNC_HI = SYNC_HALF / 2;

  logic [NH-1:0] pat_d;
  logic [NH-1:0] pat_q;
  logic          par;

  assign par = ~(^data_i);

  // frame image, first half-cell at the MSB
  for (genvar s = 0; s < SYNC_HALF; s++) begin : g_sync
    if (s < SYNC_HI) begin : g_first
      assign pat_d[NH-1-s] = (sync_i == SYNC_CMD);
    end else begin : g_second
      assign pat_d[NH-1-s] = (sync_i != SYNC_CMD);
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_data
    assign pat_d[NH-1-SYNC_HALF-2*b]   =  data_i[DW-1-b];
    assign pat_d[NH-1-SYNC_HALF-2*b-1] = ~data_i[DW-1-b];
  end

  assign pat_d[1] =  par;
  assign pat_d[0] = ~par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pat_q <= '0;
    else if (load_i)  pat_q <= pat_d;
    else if (shift_i) pat_q <= {pat_q[NH-2:0], 1'b0};
  end

  assign level_o = pat_q[NH-1];

  AST_PAR_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> $countones({$past(data_i), pat_q[1]}) % 2 == 1);  // R6
  AST_SYNC_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> level_o == ($past(sync_i) == SYNC_CMD));  // R3
endmodule

// File: rtl/mtx_bus_steer.sv
module mtx_bus_steer
  import mtx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    active_i,
  input  bus_id_e bus_i,
  input  logic    level_i,
  output logic    a_p_o,
  output logic    a_n_o,
  output logic    b_p_o,
  output logic    b_n_o
);
  logic en_a, en_b;

  assign en_a  = active_i && (bus_i == BUS_A);
  assign en_b  = active_i && (bus_i == BUS_B);
  assign a_p_o = en_a &  level_i;
  assign a_n_o = en_a & ~level_i;
  assign b_p_o = en_b &  level_i;
  assign b_n_o = en_b & ~level_i;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !(a_p_o | a_n_o | b_p_o | b_n_o));  // R9
  AST_DIFF_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (a_p_o ^ a_n_o) ^ (b_p_o ^ b_n_o));  // R7
  AST_SINGLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((a_p_o | a_n_o) && (b_p_o | b_n_o)));  // R8
endmodule

// File: rtl/mtx_word_tx.sv
module mtx_word_tx
  import mtx_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 6,
  parameter int unsigned DW        = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          cmd_sync_i,
  input  logic          bus_sel_i,
  output logic          busy_o,
  output logic          bus_a_p_o,
  output logic          bus_a_n_o,
  output logic          bus_b_p_o,
  output logic          bus_b_n_o
);
  localparam int unsigned SYNC_HALF = 2 * SYNC_BITS;
  localparam int unsigned NH        = SYNC_HALF + 2 * DW + 2;
  localparam int unsigned HW        = $clog2(NH);
  localparam logic [HW-1:0] LAST_H  = HW'(NH - 1);

  logic          busy_q;
  logic          accept;
  logic          half_end;
  logic          frame_end;
  logic [HW-1:0] half_q;
  bus_id_e       bus_q;
  logic          level;

  assign accept    = load_i && !busy_q;
  assign frame_end = half_end && (half_q == LAST_H);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= '0;
      bus_q  <= BUS_A;
    end else if (accept) begin
      busy_q <= 1'b1;
      half_q <= '0;
      bus_q  <= bus_id_e'(bus_sel_i);
    end else if (frame_end) begin
      busy_q <= 1'b0;
      half_q <= '0;
    end else if (half_end) begin
      half_q <= half_q + 1'b1;
    end
  end

  mtx_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .run_i      (busy_q),
    .half_end_o (half_end)
  );

  mtx_pattern_shifter #(.DW(DW), .SYNC_HALF(SYNC_HALF)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .data_i  (data_i),
    .sync_i  (sync_kind_e'(cmd_sync_i)),
    .shift_i (half_end),
    .level_o (level)
  );

  mtx_bus_steer u_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (busy_q),
    .bus_i    (bus_q),
    .level_i  (level),
    .a_p_o    (bus_a_p_o),
    .a_n_o    (bus_a_n_o),
    .b_p_o    (bus_b_p_o),
    .b_n_o    (bus_b_n_o)
  );

  assign busy_o = busy_q;

  AST_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && load_i && !frame_end) |=> busy_q && $stable(bus_q));  // R10
  AST_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(bus_q));  // R8
  AST_START_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_q && half_q == '0);  // R2
endmodule

// File: tb/sim_mtx_word_tx.sv
`timescale 1ns/1ps
module sim_mtx_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] data = '0;
  logic        cmd = 1'b0;
  logic        sel = 1'b0;
  logic        busy, ap, an, bp, bn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtx_word_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(data),
    .cmd_sync_i(cmd), .bus_sel_i(sel), .busy_o(busy),
    .bus_a_p_o(ap), .bus_a_n_o(an), .bus_b_p_o(bp), .bus_b_n_o(bn)
  );

  function automatic logic exp_level(input logic [15:0] w, input logic c, input int h);
    if (h < 6) return c ? (h < 3) : (h >= 3);
    if (h < 38) begin
      logic b;
      b = w[15 - (h - 6) / 2];
      return ((h - 6) % 2 == 0) ? b : ~b;
    end
    return (h == 38) ? ~(^w) : (^w);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // caller is at a falling edge; leaves at the falling edge after the frame
  task automatic send(input logic [15:0] w, input logic c, input logic s,
                      input bit disturb);
    int bad_sync = -1, bad_data = -1, bad_par = -1;
    int bad_cmp = -1, bad_other = -1, bad_busy = -1;
    data = w; cmd = c; sel = s; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    for (int k = 0; k < 240; k++) begin
      int h;
      logic lp, ln, op, on, e;
      h = k / 6;
      lp = s ? bp : ap;  ln = s ? bn : an;
      op = s ? ap : bp;  on = s ? an : bn;
      e = exp_level(w, c, h);
      if (lp !== e) begin
        if (h < 6 && bad_sync < 0) bad_sync = k;
        else if (h >= 6 && h < 38 && bad_data < 0) bad_data = k;
        else if (h >= 38 && bad_par < 0) bad_par = k;
      end
      if (ln !== ~lp && bad_cmp < 0) bad_cmp = k;
      if ((op !== 1'b0 || on !== 1'b0) && bad_other < 0) bad_other = k;
      if (busy !== 1'b1 && bad_busy < 0) bad_busy = k;
      if (disturb) begin
        if (k == 50) sel = ~s;
        if (k == 100) begin load = 1'b1; data = ~w; cmd = ~c; end
        if (k == 101) load = 1'b0;
      end
      @(negedge clk);
    end
    check(bad_sync < 0, "R3 sync pattern", bad_sync, -1);
    check(bad_data < 0, "R4/R5 data bits msb first", bad_data, -1);
    check(bad_par < 0, "R6 odd parity bit", bad_par, -1);
    check(bad_cmp < 0, "R7 negative line complement", bad_cmp, -1);
    check(bad_other < 0, "R8 unselected bus quiet", bad_other, -1);
    check(bad_busy < 0 && busy === 1'b0, "R2 busy length 240", bad_busy, -1);
    check({ap, an, bp, bn} === 4'b0, "R9 idle outputs after frame", {ap, an, bp, bn}, 0);
    if (disturb) check(bad_sync < 0 && bad_data < 0 && bad_par < 0 && bad_other < 0,
                       "R10 load during busy ignored", bad_data, -1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    check(busy === 1'b0 && {ap, an, bp, bn} === 4'b0, "R1 reset state",
          {busy, ap, an, bp, bn}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && {ap, an, bp, bn} === 4'b0, "R1 after reset release",
          {busy, ap, an, bp, bn}, 0);
    // directed corners
    send(16'h0000, 1'b1, 1'b0, 0);
    send(16'hFFFF, 1'b0, 1'b1, 0);
    send(16'h8000, 1'b1, 1'b1, 0);
    send(16'h0001, 1'b0, 1'b0, 0);
    // R8 bus latched and R10 load ignored while busy
    send(16'hA5C3, 1'b1, 1'b0, 1);
    send(16'h3C5A, 1'b0, 1'b1, 1);
    // random, back to back
    for (int i = 0; i < 20; i++)
      send(16'($urandom), 1'($urandom), 1'($urandom), 0);
    // idle stays idle with no load
    repeat (20) @(negedge clk);
    check(busy === 1'b0 && {ap, an, bp, bn} === 4'b0, "R9 long idle",
          {busy, ap, an, bp, bn}, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule